// File: doc/BRIEF.md
# Cycle-Stepped 8-bit Processor Core (Load/Store/Stack Subset)

This block is a small accumulator-style 8-bit processor core that performs exactly one bus cycle per clock. In every cycle it drives a 16-bit address, a read/write strobe and, when writing, a data byte. The byte returned by the memory system is sampled at the next clock edge. Memory is expected to answer a read within the same cycle. The core holds a program counter, an accumulator, two index registers, a stack pointer, a status register and an opcode register.

Multi-cycle instructions are sequenced by a one-hot step register. The register shifts left one position per clock and returns to its first step whenever an instruction completes. After reset, the core reads a little-endian start address from a fixed vector location and begins fetching there. It supports six kinds of instruction: immediate loads, absolute load and store of the accumulator, an index-to-stack-pointer transfer, a push of the accumulator, and a pull of the status register. Any other opcode stops the core permanently, until the next reset.

The internal registers are brought out as read-only ports so that the surrounding logic can observe the machine state.

Top module: `cpu8_core`

## Requirements
- R1: An active-low asynchronous reset clears pc_o, a_o, x_o, y_o, s_o, p_o and halt_o to zero. While reset is held, the core drives addr_o = 0xFFFC with rw_o = 1 and wdata_o = 0.
- R2: After reset, the core reads 0xFFFC in the first cycle and 0xFFFD in the second. In the third cycle it fetches from the address whose low byte came from 0xFFFC and whose high byte came from 0xFFFD, and pc_o holds that address.
- R3: In every fetch cycle, addr_o equals pc_o and rw_o = 1. On the next clock, the fetched byte becomes the current opcode, pc_o increments, and the bus reads the new pc_o.
- R4: Opcodes 0xA9, 0xA2 and 0xA0 load the byte after the opcode into a_o, x_o and y_o respectively. Each takes 2 cycles and fetches next from the opcode address + 2.
- R5: Opcode 0xAD takes 4 cycles. It reads a low address byte and then a high address byte. In its third cycle it reads the address {high, low}, then loads a_o from that byte and fetches from the opcode address + 3.
- R6: Opcode 0x8D takes 4 cycles. It reads the address bytes in the same way as R5. In its third cycle it writes a_o to {high, low} with rw_o = 0, then fetches from the opcode address + 3.
- R7: Opcode 0x9A copies x_o into s_o. It takes 2 cycles and fetches next from the opcode address + 1.
- R8: Opcode 0x48 takes 3 cycles. In its second cycle it writes a_o to 0x0100 + s_o with rw_o = 0. At the following clock, s_o decrements modulo 256.
- R9: Opcode 0x28 takes 4 cycles. It increments s_o modulo 256, reads 0x0100 + the new s_o in its third cycle, and loads that byte into p_o.
- R10: rw_o is 0 only in the write cycles of R6 and R8. In every read cycle, wdata_o is 0.
- R11: Any opcode other than those in R4 to R9 sets halt_o one clock after its fetch. halt_o then stays set, and addr_o, rw_o, wdata_o and every register output hold their values until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rdata_i | input | 8 | Read data returned for the current addr_o |
| addr_o | output | 16 | Bus address for the current cycle |
| rw_o | output | 1 | 1 = read cycle, 0 = write cycle |
| wdata_o | output | 8 | Write data, 0 in read cycles |
| halt_o | output | 1 | Sticky stop flag set by an unknown opcode |
| pc_o | output | 16 | Program counter |
| a_o | output | 8 | Accumulator |
| x_o | output | 8 | X index register |
| y_o | output | 8 | Y index register |
| s_o | output | 8 | Stack pointer (low byte of the page-1 stack address) |
| p_o | output | 8 | Status register |

## Verification
The assertions check the following properties on every cycle:
- The step register stays one-hot.
- Every fetch cycle addresses the program counter.
- Write data is idle in read cycles, and only stores and pushes ever write.
- The push write lands on page 1 and is followed by a decrement of the stack pointer.
- The halt flag is sticky and freezes the bus.

The bench's reference model covers behaviour that no single-cycle property can show: the order of the vector reads, the exact cycle count of each opcode, the assembly of absolute addresses from two operand bytes, the pull-to-status path, the wrap of the stack pointer at 0x00/0xFF, and the restart from a new vector after a reset that arrives while the core is halted.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;

  localparam logic [DW-1:0] OP_PULL_P  = 8'h28;
  localparam logic [DW-1:0] OP_PUSH_A  = 8'h48;
  localparam logic [DW-1:0] OP_STA_ABS = 8'h8D;
  localparam logic [DW-1:0] OP_X_TO_S  = 8'h9A;
  localparam logic [DW-1:0] OP_LDY_IMM = 8'hA0;
  localparam logic [DW-1:0] OP_LDX_IMM = 8'hA2;
  localparam logic [DW-1:0] OP_LDA_IMM = 8'hA9;
  localparam logic [DW-1:0] OP_LDA_ABS = 8'hAD;

  typedef enum logic [2:0] {
    CL_IMM, CL_LDA_ABS, CL_STA_ABS, CL_XFER, CL_PUSH, CL_PULL, CL_BAD
  } op_class_e;

  typedef enum logic [1:0] {DST_A, DST_X, DST_Y} imm_dst_e;

  typedef enum logic [1:0] {BT_LO, BT_HI, BT_RUN} boot_e;
endpackage

// File: rtl/cpu8_step.sv
module cpu8_step #(
  parameter int STEPS = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             restart_i,
  output logic [STEPS-1:0] step_o
);
  localparam logic [STEPS-1:0] FIRST = STEPS'(1);

  logic [STEPS-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     step_q <= FIRST;
    else if (restart_i)              step_q <= FIRST;
    else if (adv_i && step_q[STEPS-1]) step_q <= FIRST; // wrap keeps one-hot
    else if (adv_i)                  step_q <= step_q << 1;
  end

  assign step_o = step_q;
endmodule

// File: rtl/cpu8_decode.sv
module cpu8_decode
  import cpu8_pkg::*;
(
  input  logic [DW-1:0] ir_i,
  output op_class_e     cls_o,
  output imm_dst_e      dst_o
);
  always_comb begin
    dst_o = DST_A;
    unique case (ir_i)
      OP_LDA_IMM: cls_o = CL_IMM;
      OP_LDX_IMM: begin cls_o = CL_IMM; dst_o = DST_X; end
      OP_LDY_IMM: begin cls_o = CL_IMM; dst_o = DST_Y; end
      OP_LDA_ABS: cls_o = CL_LDA_ABS;
      OP_STA_ABS: cls_o = CL_STA_ABS;
      OP_X_TO_S:  cls_o = CL_XFER;
      OP_PUSH_A:  cls_o = CL_PUSH;
      OP_PULL_P:  cls_o = CL_PULL;
      default:    cls_o = CL_BAD;
    endcase
  end
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter int            STEPS      = 7,
  parameter logic [AW-1:0] VEC_ADDR   = 16'hFFFC,
  parameter logic [DW-1:0] STACK_PAGE = 8'h01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic          rw_o,
  output logic [DW-1:0] wdata_o,
  output logic          halt_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] x_o,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] s_o,
  output logic [DW-1:0] p_o
);
  localparam logic [AW-1:0] VEC_HI_ADDR = VEC_ADDR + AW'(1);

  logic [AW-1:0] pc_q, pc_d, addr_q, addr_d, pc_inc;
  logic [DW-1:0] a_q, a_d, x_q, x_d, y_q, y_d, s_q, s_d, p_q, p_d;
  logic [DW-1:0] ir_q, ir_d, tmp_q, tmp_d, wdata_q, wdata_d;
  logic          rw_q, rw_d, halt_q, halt_d;
  boot_e         boot_q, boot_d;
  logic          adv, restart, run_w, late_w;
  logic [STEPS-1:0] step_q;
  op_class_e     cls;
  imm_dst_e      dst;

  cpu8_step #(.STEPS(STEPS)) u_step (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (adv),
    .restart_i(restart),
    .step_o   (step_q)
  );

  cpu8_decode u_dec (
    .ir_i (ir_q),
    .cls_o(cls),
    .dst_o(dst)
  );

  assign pc_inc = pc_q + AW'(1);
  assign run_w  = (boot_q == BT_RUN);
  assign late_w = |step_q[STEPS-1:4];

  always_comb begin
    pc_d = pc_q; a_d = a_q; x_d = x_q; y_d = y_q; s_d = s_q; p_d = p_q;
    ir_d = ir_q; tmp_d = tmp_q; addr_d = addr_q; rw_d = rw_q; wdata_d = wdata_q;
    halt_d = halt_q; boot_d = boot_q;
    adv = 1'b0; restart = 1'b0;
    if (!halt_q) begin
      rw_d    = 1'b1;
      wdata_d = '0;
      unique case (boot_q)
        BT_LO: begin
          pc_d[DW-1:0] = rdata_i;
          addr_d       = VEC_HI_ADDR;
          boot_d       = BT_HI;
        end
        BT_HI: begin
          pc_d   = {rdata_i, pc_q[DW-1:0]};
          addr_d = {rdata_i, pc_q[DW-1:0]};
          boot_d = BT_RUN;
        end
        default: begin
          if (step_q[0]) begin
            ir_d = rdata_i; pc_d = pc_inc; addr_d = pc_inc; adv = 1'b1;
          end else if (step_q[1]) begin
            case (cls)
              CL_IMM: begin
                case (dst)
                  DST_A:   a_d = rdata_i;
                  DST_X:   x_d = rdata_i;
                  default: y_d = rdata_i;
                endcase
                pc_d = pc_inc; addr_d = pc_inc; restart = 1'b1;
              end
              CL_LDA_ABS, CL_STA_ABS: begin
                tmp_d = rdata_i; pc_d = pc_inc; addr_d = pc_inc; adv = 1'b1;
              end
              CL_XFER: begin
                s_d = x_q; addr_d = pc_q; restart = 1'b1;
              end
              CL_PUSH: begin
                addr_d = {STACK_PAGE, s_q}; rw_d = 1'b0; wdata_d = a_q; adv = 1'b1;
              end
              CL_PULL: begin
                s_d = s_q + DW'(1); addr_d = pc_q; adv = 1'b1;
              end
              default: begin
                halt_d = 1'b1; rw_d = rw_q; wdata_d = wdata_q;
              end
            endcase
          end else if (step_q[2]) begin
            case (cls)
              CL_LDA_ABS: begin
                pc_d = pc_inc; addr_d = {rdata_i, tmp_q}; adv = 1'b1;
              end
              CL_STA_ABS: begin
                pc_d = pc_inc; addr_d = {rdata_i, tmp_q};
                rw_d = 1'b0; wdata_d = a_q; adv = 1'b1;
              end
              CL_PUSH: begin
                s_d = s_q - DW'(1); addr_d = pc_q; restart = 1'b1;
              end
              default: begin
                addr_d = {STACK_PAGE, s_q}; adv = 1'b1;
              end
            endcase
          end else if (step_q[3]) begin
            if (cls == CL_LDA_ABS) a_d = rdata_i;
            if (cls == CL_PULL)    p_d = rdata_i;
            addr_d = pc_q; restart = 1'b1;
          end else if (late_w) begin
            addr_d = pc_q; restart = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0; a_q <= '0; x_q <= '0; y_q <= '0; s_q <= '0; p_q <= '0;
      ir_q <= '0; tmp_q <= '0; addr_q <= VEC_ADDR; rw_q <= 1'b1;
      wdata_q <= '0; halt_q <= 1'b0; boot_q <= BT_LO;
    end else begin
      pc_q <= pc_d; a_q <= a_d; x_q <= x_d; y_q <= y_d; s_q <= s_d; p_q <= p_d;
      ir_q <= ir_d; tmp_q <= tmp_d; addr_q <= addr_d; rw_q <= rw_d;
      wdata_q <= wdata_d; halt_q <= halt_d; boot_q <= boot_d;
    end
  end

  assign addr_o  = addr_q;
  assign rw_o    = rw_q;
  assign wdata_o = wdata_q;
  assign halt_o  = halt_q;
  assign pc_o    = pc_q;
  assign a_o     = a_q;
  assign x_o     = x_q;
  assign y_o     = y_q;
  assign s_o     = s_q;
  assign p_o     = p_q;
endmodule

// File: rtl/cpu8_core_chk.sv
module cpu8_core_chk
  import cpu8_pkg::*;
#(
  parameter int            STEPS      = 7,
  parameter logic [DW-1:0] STACK_PAGE = 8'h01
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    addr_o,
  input logic [AW-1:0]    pc_o,
  input logic             rw_o,
  input logic             halt_o,
  input logic [DW-1:0]    wdata_o,
  input logic [DW-1:0]    a_o,
  input logic [DW-1:0]    s_o,
  input logic [DW-1:0]    ir_q,
  input logic [STEPS-1:0] step_q,
  input logic             run_w
);
  logic push_wr;
  assign push_wr = run_w && !halt_o && (ir_q == OP_PUSH_A) && step_q[2];

  AST_STEP_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(step_q)); // R3
  AST_FETCH_AT_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_w && step_q[0] && !halt_o) |-> (addr_o == pc_o && rw_o)); // R3
  AST_WDATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rw_o |-> (wdata_o == '0)); // R10
  AST_WRITE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rw_o |-> (run_w && (ir_q == OP_PUSH_A || ir_q == OP_STA_ABS))); // R10
  AST_PUSH_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_wr |-> (!rw_o && addr_o == {STACK_PAGE, s_o} && wdata_o == a_o)); // R8
  AST_PUSH_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_wr |=> (s_o == DW'($past(s_o) - DW'(1)))); // R8
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o); // R11
  AST_HALT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> ($stable(addr_o) && $stable(rw_o) && $stable(pc_o) && $stable(s_o) && $stable(a_o))); // R11
endmodule

bind cpu8_core cpu8_core_chk #(.STEPS(STEPS), .STACK_PAGE(STACK_PAGE)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_o (addr_o),
  .pc_o   (pc_o),
  .rw_o   (rw_o),
  .halt_o (halt_o),
  .wdata_o(wdata_o),
  .a_o    (a_o),
  .s_o    (s_o),
  .ir_q   (ir_q),
  .step_q (step_q),
  .run_w  (run_w)
);

// File: tb/cpu8_core_test.sv
`timescale 1ns/1ps
module cpu8_core_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  rdata;
  logic [15:0] addr_o, pc_o;
  logic        rw_o, halt_o;
  logic [7:0]  wdata_o, a_o, x_o, y_o, s_o, p_o;

  logic [7:0] mem [0:4095];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cpu8_core uut (
    .clk_i(clk), .rst_ni(rst_ni), .rdata_i(rdata), .addr_o(addr_o), .rw_o(rw_o),
    .wdata_o(wdata_o), .halt_o(halt_o), .pc_o(pc_o), .a_o(a_o), .x_o(x_o),
    .y_o(y_o), .s_o(s_o), .p_o(p_o)
  );

  assign rdata = mem[addr_o[11:0]];
  always @(posedge clk) if (rst_ni && !rw_o) mem[addr_o[11:0]] <= wdata_o;

  // behavioural reference model: state as seen after the last clock edge
  logic [15:0] m_pc, m_addr;
  logic [7:0]  m_a, m_x, m_y, m_s, m_p, m_op, m_tmp, m_wd;
  bit          m_rw, m_halt;
  int          m_boot, m_ph;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string ctx_req();
    if (m_boot != 2) return "R2";
    if (m_ph == 0)   return "R3";
    case (m_op)
      8'hA9, 8'hA2, 8'hA0: return "R4";
      8'hAD: return "R5";
      8'h8D: return "R6";
      8'h9A: return "R7";
      8'h48: return "R8";
      8'h28: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic compare_all(input string req);
    chk(req, "addr", addr_o, m_addr);
    chk(req, "rw", 16'(rw_o), 16'(m_rw));
    chk("R10", "wdata", 16'(wdata_o), 16'(m_wd));
    chk("R11", "halt", 16'(halt_o), 16'(m_halt));
    chk(req, "pc", pc_o, m_pc);
    chk(req, "a", 16'(a_o), 16'(m_a));
    chk(req, "x", 16'(x_o), 16'(m_x));
    chk(req, "y", 16'(y_o), 16'(m_y));
    chk(req, "s", 16'(s_o), 16'(m_s));
    chk(req, "p", 16'(p_o), 16'(m_p));
  endtask

  task automatic model_reset();
    m_pc = 0; m_a = 0; m_x = 0; m_y = 0; m_s = 0; m_p = 0; m_op = 0; m_tmp = 0;
    m_addr = 16'hFFFC; m_rw = 1; m_wd = 0; m_halt = 0; m_boot = 0; m_ph = 0;
  endtask

  task automatic fetch();
    m_addr = m_pc; m_ph = 0;
  endtask

  task automatic model_advance();
    logic [7:0] rd;
    rd = mem[m_addr[11:0]];
    if (m_halt) return;
    m_rw = 1; m_wd = 0;
    if (m_boot == 0) begin
      m_pc[7:0] = rd; m_addr = 16'hFFFD; m_boot = 1;
    end else if (m_boot == 1) begin
      m_pc[15:8] = rd; m_addr = m_pc; m_boot = 2; m_ph = 0;
    end else if (m_ph == 0) begin
      m_op = rd; m_pc++; m_addr = m_pc; m_ph = 1;
    end else begin
      case (m_op)
        8'hA9: begin m_a = rd; m_pc++; fetch(); end
        8'hA2: begin m_x = rd; m_pc++; fetch(); end
        8'hA0: begin m_y = rd; m_pc++; fetch(); end
        8'h9A: begin m_s = m_x; fetch(); end
        8'hAD, 8'h8D: begin
          if (m_ph == 1) begin m_tmp = rd; m_pc++; m_addr = m_pc; m_ph = 2; end
          else if (m_ph == 2) begin
            m_pc++; m_addr = {rd, m_tmp}; m_ph = 3;
            if (m_op == 8'h8D) begin m_rw = 0; m_wd = m_a; end
          end else begin
            if (m_op == 8'hAD) m_a = rd;
            fetch();
          end
        end
        8'h48: begin
          if (m_ph == 1) begin m_addr = {8'h01, m_s}; m_rw = 0; m_wd = m_a; m_ph = 2; end
          else begin m_s--; fetch(); end
        end
        8'h28: begin
          if (m_ph == 1) begin m_s++; m_addr = m_pc; m_ph = 2; end
          else if (m_ph == 2) begin m_addr = {8'h01, m_s}; m_ph = 3; end
          else begin m_p = rd; fetch(); end
        end
        default: m_halt = 1;
      endcase
    end
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_ni = 0;
    model_reset();
    #1 compare_all("R1");
    @(negedge clk);
    compare_all("R1");
    model_advance();
    rst_ni = 1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all(ctx_req());
      model_advance();
    end
  endtask

  localparam int PLEN = 30;
  logic [7:0] prog [0:PLEN-1] = '{
    8'hA9, 8'h5A, 8'hA2, 8'hF0, 8'hA0, 8'h33, 8'h9A, 8'h48, 8'h8D, 8'h00,
    8'h03, 8'hA9, 8'h00, 8'hAD, 8'hF0, 8'h01, 8'h28, 8'hA9, 8'hC3, 8'h48,
    8'h28, 8'hAD, 8'h00, 8'h04, 8'hA2, 8'h00, 8'h9A, 8'h48, 8'h28, 8'hFF
  };

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    for (int i = 0; i < PLEN; i++) mem[12'h200 + i] = prog[i];
    mem[12'hFFC] = 8'h00; mem[12'hFFD] = 8'h02;
    mem[12'h400] = 8'h77;
    model_reset();

    reset_dut();
    run(90);
    chk("R6", "mem[0300]", 16'(mem[12'h300]), 16'h005A);
    chk("R8", "mem[01F0]", 16'(mem[12'h1F0]), 16'h00C3);
    chk("R8", "mem[0100] wrap push", 16'(mem[12'h100]), 16'h0077);
    chk("R5", "a after abs load", 16'(a_o), 16'h0077);
    chk("R4", "y after imm load", 16'(y_o), 16'h0033);
    chk("R7", "x/s after transfer", 16'(s_o), 16'h0000);
    chk("R9", "p after wrapped pull", 16'(p_o), 16'h0077);
    chk("R11", "halt sticky", 16'(halt_o), 16'h0001);
    chk("R11", "pc frozen", pc_o, 16'h021E);

    mem[12'hFFC] = 8'h00; mem[12'hFFD] = 8'h08;
    mem[12'h800] = 8'hA9; mem[12'h801] = 8'h11; mem[12'h802] = 8'hFF;
    reset_dut();
    run(8);
    chk("R2", "a from new vector", 16'(a_o), 16'h0011);
    chk("R11", "halt after new program", 16'(halt_o), 16'h0001);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule